// File: doc/BRIEF.md
# Byte-Addressable Fuse Readback Window

This block gives a host a read-only view of a fuse array at byte granularity. The fuse array is stored as 32-bit rows behind a synchronous row-read port, and the data comes back one cycle after a request. The host presents a byte address, an access size of 1, 2 or 4 bytes and a read or write strobe. The block works out which rows hold the requested bytes and fetches them. It then returns the bytes in little-endian order, right-justified and zero-extended to 32 bits.

An access whose bytes lie in one row needs a single fetch. An unaligned access that runs past the end of a row needs two fetches in back-to-back cycles. The block joins the two rows into a 64-bit value, with the higher-numbered row on top, and shifts that value down by the byte offset. The block accepts only one transaction at a time and lowers its ready output while fetches are in progress. It rejects writes, reads with an unsupported size and reads that run past the end of the window with an error pulse, and none of these touch the row port.

Top module: `fuse_rdwin`

## Requirements
- R1: The window covers byte addresses 0 to 0xBFF. A read with `host_addr + host_size > 0xC00` is answered one cycle after acceptance with `host_rvalid`=1, `host_err`=1 and `host_rdata`=0, and no row is fetched.
- R2: Only sizes 1, 2 and 4 are legal. A read with any other size gets the same error response as in R1, with no row fetched.
- R3: A write accepted while ready is high raises `host_err` for one cycle, one cycle after acceptance, with `host_rvalid`=0. It fetches no row and changes nothing later reads return. If `host_rd` and `host_wr` are both high, the request is treated as a write.
- R4: The first row fetched is `host_addr >> 2`. The last row is `(host_addr + host_size - 1) >> 2`, and it is fetched as a second access only when it differs from the first.
- R5: A legal read that stays within one row drives `host_ready` low for exactly one cycle. It returns `host_rvalid`=1 with `host_err`=0 two cycles after acceptance.
- R6: A legal read that crosses a row boundary fetches the lower row, then the next row in the following cycle. `host_ready` is low for two cycles and `host_rvalid` comes three cycles after acceptance. At most two back-to-back fetches belong to one access.
- R7: Read data is `{row[last], row[first]} >> (8 * (host_addr mod 4))`, so byte k of `host_rdata` is fuse byte `host_addr + k` (little-endian).
- R8: `host_rdata` bits at and above `8 * host_size` are zero.
- R9: Read or write strobes while `host_ready` is low are ignored: they cause no error, no fetch and no change to the result in flight.
- R10: While reset is held, `host_ready`=1, `host_rvalid`=0, `host_err`=0 and `row_rd_en`=0.
- R11: Row data is sampled in the cycle after `row_rd_en`, which matches a row port with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd | input | 1 | Read request, taken when host_ready is high |
| host_wr | input | 1 | Write request, always rejected |
| host_addr | input | 12 | Byte address within the window |
| host_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| host_ready | output | 1 | Block idle and able to take a request |
| host_rvalid | output | 1 | One-cycle pulse: read response valid |
| host_rdata | output | 32 | Read data, right-justified, zero-extended |
| host_err | output | 1 | One-cycle pulse: request rejected |
| row_rd_en | output | 1 | Row fetch strobe to the fuse array |
| row_rd_idx | output | 10 | Row index for the fetch |
| row_rd_data | input | 32 | Row contents, valid the cycle after row_rd_en |

## Verification
The bench sweeps every start address from 0 to 0xC00 with each legal size. This covers every byte offset against every row boundary, including the last bytes of the window. A design with the wrong row order in the 64-bit merge, or a shift that goes the wrong way, would return swapped or misplaced bytes at offsets 1 to 3. A design that skipped the second fetch would return zeros in the upper lanes. Reads that overrun 0xC00 by one byte, and sizes 0, 3, 5, 6 and 7, target the bound and size checks: a design that got these wrong would fetch a row past the array or return data where it should flag an error. A write strobe raised in the middle of a crossing read checks that the busy cycles ignore the host; a design that did not would either drop the pending result or raise a false error.

// File: rtl/fuse_rdwin_pkg.sv
// Package: shared types for the fuse readback window.
// Assumes: nothing beyond IEEE 1800-2017.
package fuse_rdwin_pkg;

    // Sequencer states: idle, waiting for first row, waiting for second row.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_LO = 2'd1,
        ST_WAIT_HI = 2'd2
    } rdwin_state_e;

endpackage

// File: rtl/fuse_rdwin_decode.sv
// Module: fuse_rdwin_decode
// Purpose: combinational check of a host request. It says whether the size
//          is legal and the bytes lie inside the window, gives the first row
//          index and says whether the access runs into the next row.
// Assumes: ROW_BYTES is a power of two; ADDR_W covers WIN_BYTES.
module fuse_rdwin_decode #(
    parameter int ADDR_W    = 12,
    parameter int SIZE_W    = 3,
    parameter int WIN_BYTES = 3072,
    parameter int ROW_BYTES = 4,
    parameter int OFF_W     = $clog2(ROW_BYTES),
    parameter int RIDX_W    = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              legal,
    output logic              spans,
    output logic [RIDX_W-1:0] lo_idx
);

    logic [ADDR_W:0] end_excl;
    logic            size_ok;
    logic            in_win;

    // Size legality, window bound, first row and row-crossing detection.
    always_comb begin
        end_excl = {1'b0, addr} + (ADDR_W+1)'(size);
        size_ok  = (size != '0) && ((size & (size - 1'b1)) == '0)
                   && (int'(size) <= ROW_BYTES);
        in_win   = (end_excl <= (ADDR_W+1)'(WIN_BYTES));
        legal    = size_ok && in_win;
        lo_idx   = addr[ADDR_W-1:OFF_W];
        spans    = (int'(addr[OFF_W-1:0]) + int'(size)) > ROW_BYTES;
    end

endmodule

// File: rtl/fuse_rdwin_align.sv
// Module: fuse_rdwin_align
// Purpose: joins two rows into one double-width value (upper row on top),
//          picks bytes starting at the byte offset and zeroes every lane
//          at or above the access size.
// Assumes: ROW_W is a multiple of 8; size <= ROW_W/8 for legal accesses.
module fuse_rdwin_align #(
    parameter int ROW_W  = 32,
    parameter int SIZE_W = 3,
    parameter int OFF_W  = $clog2(ROW_W / 8)
) (
    input  logic [ROW_W-1:0]  lo_row,
    input  logic [ROW_W-1:0]  hi_row,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output logic [ROW_W-1:0]  data
);

    localparam int LANES = ROW_W / 8;

    logic [2*ROW_W-1:0] pair;
    assign pair = {hi_row, lo_row};

    // One byte lane per generate step: shifted pick, then size mask.
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic [7:0] pick;
        assign pick = pair[int'({off, 3'b000}) + lane*8 +: 8];
        assign data[lane*8 +: 8] = (lane < int'(size)) ? pick : 8'h00;
    end

endmodule

// File: rtl/fuse_rdwin_ctrl.sv
// Module: fuse_rdwin_ctrl
// Purpose: takes one host request at a time, issues one or two row
//          fetches on the one-cycle-latency row port, and registers the
//          response (data, valid pulse, error pulse).
// Assumes: row_rd_data is valid exactly one cycle after row_rd_en.
module fuse_rdwin_ctrl
    import fuse_rdwin_pkg::*;
#(
    parameter int ROW_W  = 32,
    parameter int SIZE_W = 3,
    parameter int OFF_W  = 2,
    parameter int RIDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              legal,
    input  logic              spans,
    input  logic [RIDX_W-1:0] lo_idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    input  logic [ROW_W-1:0]  row_rd_data,
    input  logic [ROW_W-1:0]  aligned,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic              host_err,
    output logic [ROW_W-1:0]  host_rdata,
    output logic              row_rd_en,
    output logic [RIDX_W-1:0] row_rd_idx,
    output logic [ROW_W-1:0]  align_lo,
    output logic [ROW_W-1:0]  align_hi,
    output logic [OFF_W-1:0]  off_q,
    output logic [SIZE_W-1:0] size_q
);

    rdwin_state_e      state;
    logic              span_q;
    logic [RIDX_W-1:0] idx_q;
    logic [ROW_W-1:0]  lo_row_q;
    logic              rvalid_q;
    logic              err_q;
    logic [ROW_W-1:0]  rdata_q;
    logic              take_rd;
    logic              reject;

    // Request classification while idle.
    always_comb begin
        host_ready = (state == ST_IDLE);
        take_rd    = host_ready && host_rd && !host_wr && legal;
        reject     = host_ready && (host_wr || (host_rd && !legal));
    end

    // Row port drive: first row on acceptance, next row when crossing.
    always_comb begin
        row_rd_en  = take_rd || ((state == ST_WAIT_LO) && span_q);
        row_rd_idx = take_rd ? lo_idx : idx_q + 1'b1;
    end

    // Row selection for the aligner: second row present only in WAIT_HI.
    always_comb begin
        align_lo = (state == ST_WAIT_HI) ? lo_row_q : row_rd_data;
        align_hi = (state == ST_WAIT_HI) ? row_rd_data : '0;
    end

    // Sequencer and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            span_q   <= 1'b0;
            idx_q    <= '0;
            off_q    <= '0;
            size_q   <= '0;
            lo_row_q <= '0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take_rd) begin
                        span_q <= spans;
                        idx_q  <= lo_idx;
                        off_q  <= off;
                        size_q <= size;
                        state  <= ST_WAIT_LO;
                    end else if (reject) begin
                        err_q    <= 1'b1;
                        rvalid_q <= !host_wr;
                        rdata_q  <= '0;
                    end
                end
                ST_WAIT_LO: begin
                    lo_row_q <= row_rd_data;
                    if (span_q) begin
                        state <= ST_WAIT_HI;
                    end else begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= aligned;
                        state    <= ST_IDLE;
                    end
                end
                ST_WAIT_HI: begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= aligned;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign host_rvalid = rvalid_q;
    assign host_err    = err_q;
    assign host_rdata  = rdata_q;

    // R6
    two_fetch_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_rd_en && !host_ready) |=> !row_rd_en);

    // R3
    wr_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_wr) |-> !row_rd_en);

    // R1
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && host_err) |-> (host_rdata == '0));

    // R8
    size_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && !host_err) |-> ((host_rdata >> {size_q, 3'b000}) == '0));

    // R5
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd |=> !host_ready);

    // R9
    busy_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |=> !host_err);

    // R11
    data_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && !host_err) |-> $past(!host_ready));

endmodule

// File: rtl/fuse_rdwin.sv
// Module: fuse_rdwin (top)
// Purpose: read-only byte window onto a fuse array of ROW_W-bit rows.
//          Wires decode, sequencer and aligner together.
// Assumes: the fuse array answers row reads one cycle after row_rd_en;
//          host issues requests only while host_ready is high.
module fuse_rdwin #(
    parameter int WIN_BYTES = 3072,
    parameter int ADDR_W    = 12,
    parameter int ROW_W     = 32,
    parameter int SIZE_W    = 3,
    parameter int ROW_BYTES = ROW_W / 8,
    parameter int OFF_W     = $clog2(ROW_BYTES),
    parameter int RIDX_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [SIZE_W-1:0] host_size,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [ROW_W-1:0]  host_rdata,
    output logic              host_err,
    output logic              row_rd_en,
    output logic [RIDX_W-1:0] row_rd_idx,
    input  logic [ROW_W-1:0]  row_rd_data
);

    logic              legal;
    logic              spans;
    logic [RIDX_W-1:0] lo_idx;
    logic [ROW_W-1:0]  aligned;
    logic [ROW_W-1:0]  align_lo;
    logic [ROW_W-1:0]  align_hi;
    logic [OFF_W-1:0]  off_q;
    logic [SIZE_W-1:0] size_q;

    fuse_rdwin_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIN_BYTES(WIN_BYTES),
        .ROW_BYTES(ROW_BYTES), .OFF_W(OFF_W), .RIDX_W(RIDX_W)
    ) u_decode (
        .addr   (host_addr),
        .size   (host_size),
        .legal  (legal),
        .spans  (spans),
        .lo_idx (lo_idx)
    );

    fuse_rdwin_ctrl #(
        .ROW_W(ROW_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W), .RIDX_W(RIDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .legal       (legal),
        .spans       (spans),
        .lo_idx      (lo_idx),
        .off         (host_addr[OFF_W-1:0]),
        .size        (host_size),
        .row_rd_data (row_rd_data),
        .aligned     (aligned),
        .host_ready  (host_ready),
        .host_rvalid (host_rvalid),
        .host_err    (host_err),
        .host_rdata  (host_rdata),
        .row_rd_en   (row_rd_en),
        .row_rd_idx  (row_rd_idx),
        .align_lo    (align_lo),
        .align_hi    (align_hi),
        .off_q       (off_q),
        .size_q      (size_q)
    );

    fuse_rdwin_align #(
        .ROW_W(ROW_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)
    ) u_align (
        .lo_row (align_lo),
        .hi_row (align_hi),
        .off    (off_q),
        .size   (size_q),
        .data   (aligned)
    );

endmodule

// File: tb/fuse_rdwin_tb.sv
`timescale 1ns/1ps
module fuse_rdwin_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [2:0]  host_size = '0;
    logic        host_ready;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        host_err;
    logic        row_rd_en;
    logic [9:0]  row_rd_idx;
    logic [31:0] row_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int fetch_total = 0;
    int fetch_prev = -1;
    int fetch_last = -1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fuse_rdwin u_dut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_err(host_err),
        .row_rd_en(row_rd_en), .row_rd_idx(row_rd_idx), .row_rd_data(row_rd_data)
    );

    // Fuse row contents, computed from the index.
    function automatic logic [31:0] row_val(input int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'hC3A5_0F17;
    endfunction

    // Row port model with one cycle latency, plus a fetch log.
    always @(posedge clk) begin
        if (row_rd_en) begin
            row_rd_data <= row_val(int'(row_rd_idx));
            fetch_prev  <= fetch_last;
            fetch_last  <= int'(row_rd_idx);
            fetch_total <= fetch_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One transaction with expectations computed from the requirements.
    task automatic txn(input int addr, input int size, input bit wr, input bit poke);
        bit          legal, spans;
        int          exp_lat, lat, f0, nf, lo, hi;
        bit          got_v, got_e, rdy1, rdy2;
        logic [31:0] got_d, exp_d;
        legal = (size == 1 || size == 2 || size == 4) && (addr + size <= 32'hC00);
        lo    = addr / 4;
        hi    = (addr + size - 1) / 4;
        spans = legal && (hi != lo);
        exp_d = '0;
        if (legal && !wr)
            for (int b = 0; b < size; b++)
                exp_d[8*b +: 8] = row_val((addr + b) / 4)[8*((addr + b) % 4) +: 8];
        exp_lat = (!legal || wr) ? 1 : (spans ? 3 : 2);
        @(negedge clk);
        f0 = fetch_total;
        host_rd = !wr; host_wr = wr;
        host_addr = 12'(addr); host_size = 3'(size);
        lat = 0; got_v = 0; got_e = 0; got_d = '0; rdy1 = 1; rdy2 = 1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1) begin rdy1 = host_ready; host_rd = 0; host_wr = poke; end
            if (k == 2) begin rdy2 = host_ready; host_wr = 0; end
            if (lat == 0 && (host_rvalid || host_err)) begin
                lat = k; got_v = host_rvalid; got_e = host_err; got_d = host_rdata;
                if (k >= 2) break;
            end
        end
        host_wr = 0;
        nf = fetch_total - f0;
        if (wr) begin
            // R3: write gives err pulse only, no fetch
            chk(lat == 1 && got_e && !got_v, "R3", "write response", {lat, got_e, got_v}, {32'd1, 1'b1, 1'b0});
            chk(nf == 0, "R3", "write fetch count", nf, 0);
        end else if (!legal) begin
            // R1 / R2: error response, zero data, no fetch
            chk(lat == 1 && got_e && got_v && got_d == 0, (size == 1 || size == 2 || size == 4) ? "R1" : "R2",
                "illegal read response", {lat, got_e, got_v, got_d}, {32'd1, 1'b1, 1'b1, 32'd0});
            chk(nf == 0, "R1", "illegal fetch count", nf, 0);
        end else begin
            // R5 / R6: latency, ready low while busy
            chk(lat == exp_lat && got_v && !got_e, spans ? "R6" : "R5", "latency", lat, exp_lat);
            chk(!rdy1 && (spans ? !rdy2 : rdy2), spans ? "R6" : "R5", "ready", {rdy1, rdy2}, {1'b0, !spans});
            // R7 / R8: merged, shifted, masked data
            chk(got_d == exp_d, spans ? "R7" : "R8", "data", got_d, exp_d);
            // R4 / R11: fetched rows
            if (spans)
                chk(nf == 2 && fetch_prev == lo && fetch_last == hi, "R4", "two-row fetch",
                    {nf, fetch_prev, fetch_last}, {2, lo, hi});
            else
                chk(nf == 1 && fetch_last == lo, "R11", "one-row fetch", {nf, fetch_last}, {1, lo});
        end
        if (poke)
            chk(!got_e, "R9", "busy strobe ignored", got_e, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(host_ready && !host_rvalid && !host_err && !row_rd_en, "R10", "reset outputs",
            {host_ready, host_rvalid, host_err, row_rd_en}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        // Full sweep of legal sizes over the window and one byte past it.
        for (int a = 0; a <= 32'hC00; a++) begin
            txn(a, 1, 0, 0);
            txn(a, 2, 0, 0);
            txn(a, 4, 0, 0);
        end
        // Top-of-window overruns (R1).
        txn(32'hBFF, 2, 0, 0);
        txn(32'hBFD, 4, 0, 0);
        txn(32'hFFF, 1, 0, 0);
        // Illegal sizes (R2).
        for (int a = 0; a < 32'hC00; a += 61) begin
            txn(a, 0, 0, 0); txn(a, 3, 0, 0); txn(a, 5, 0, 0);
            txn(a, 6, 0, 0); txn(a, 7, 0, 0);
        end
        // Writes (R3), then readback unchanged.
        txn(32'h010, 4, 1, 0);
        txn(32'h010, 4, 0, 0);
        txn(32'h7FE, 2, 1, 0);
        txn(32'h7FE, 4, 0, 0);
        // Strobes while busy (R9).
        txn(32'h123, 4, 0, 1);
        txn(32'h200, 1, 0, 1);
        txn(32'hBFE, 2, 0, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule